// File: doc/BRIEF.md
# Locked Read Sequence Monitor

This block watches the read address and read data channels of an AXI interface and checks the ordering rules for locked read sequences. It keeps a count of read transactions in flight: an address handshake adds one, and a read data handshake that carries the final beat removes one. From that count and a small sequence state machine it decides, on each accepted read address, whether that address breaks a locked-access rule.

Four hard rules raise error bits. A locked sequence may only open when the bus has drained. Every locked address must reuse the ID of the opening one. The unlocked address that closes the sequence may only be issued once all the locked transactions have completed. No further address may be issued until that closing transaction has finished. Three advisory rules raise warning bits: more than two locked transactions, a locked address outside the 4KB page of the first one, and a change of protection or cache attributes inside the sequence. All seven bits are sticky until reset. The block is meant to be instantiated beside a manager port in simulation or silicon debug logic and has no effect on the bus.

Top module: `lockrd_monitor`

## Requirements
- R1: While rst_n is low (sampled at a rising clock edge) every error and warning output is cleared to 0 and the outstanding count returns to zero.
- R2: An accepted address with ar_lock equal to 2'b10 is locked; 2'b00, 2'b01 and 2'b11 are unlocked. A locked address accepted while no locked sequence is active opens a sequence and sets err_start if any read is still outstanding. A final-beat read handshake (r_valid, r_ready and r_last high) in that same cycle counts as already completed.
- R3: A locked address accepted inside an open sequence whose ar_id differs from the ID of the opening address sets err_id.
- R4: An unlocked address accepted inside an open sequence closes it and sets err_last if any read is still outstanding, a same-cycle final beat counting as completed.
- R5: After the closing unlocked address, any address accepted before the outstanding count has drained to zero sets err_end; a same-cycle final beat counts as completed, and once drained the monitor behaves as with no sequence active.
- R6: A third or later locked address within one sequence sets warn_count.
- R7: A locked address within a sequence whose bits [ADDR_W-1:12] differ from those of the opening address sets warn_region; a difference in bits [11:0] alone sets nothing.
- R8: A locked address within a sequence whose ar_prot or ar_cache differs from that of the opening address sets warn_attr.
- R9: Rules are judged only in cycles where ar_valid and ar_ready are both high; a presented but unaccepted address changes no output, and a set bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| ar_addr | input | ADDR_W | Read address |
| ar_lock | input | 2 | Lock type, 2'b10 means locked |
| ar_cache | input | 4 | Cache attributes |
| ar_prot | input | 3 | Protection attributes |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Final beat of a read burst |
| err_start | output | 1 | Locked sequence opened with reads outstanding |
| err_id | output | 1 | Locked address used a different ID |
| err_last | output | 1 | Sequence closed before locked reads completed |
| err_end | output | 1 | Address issued before the closing read completed |
| warn_count | output | 1 | More than two locked addresses in a sequence |
| warn_region | output | 1 | Locked address left the opening 4KB page |
| warn_attr | output | 1 | Protection or cache attributes changed |

## Verification
An address handshake and the final beat of an earlier read can land in the same cycle, and the rules that demand a drained bus must treat that completion as done. The bench drives both handshakes in one cycle at each draining point: opening a sequence with one read outstanding, closing it with one locked read outstanding, and issuing the next address while the closing read finishes. It then expects every error bit to stay clear, while the same addresses issued one cycle before the completion are expected to set err_start, err_last and err_end respectively.

// File: rtl/lockrd_pkg.sv
// Shared types for the locked read sequence monitor.
// Assumes: lock field is two bits wide, value 2'b10 marks a locked request.
package lockrd_pkg;

    // Sequence state of the monitor.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOCKED    = 2'd1,
        ST_UNLOCKING = 2'd2
    } seq_state_t;

    localparam logic [1:0] LOCK_LOCKED = 2'b10;

    // Page boundary: bits at and above this index select a 4KB region.
    localparam int PAGE_LSB = 12;

    // One bit per rule; the same layout is used for events and sticky flags.
    typedef struct packed {
        logic err_start;
        logic err_id;
        logic err_last;
        logic err_end;
        logic warn_count;
        logic warn_region;
        logic warn_attr;
    } mon_flags_t;

endpackage

// File: rtl/lockrd_outstanding.sv
// Outstanding read counter.
// Adds one per accepted read address and removes one per final read beat.
// Saturates at both ends. Also exports the count as it stands once a
// same-cycle completion is taken into account, for the drain rules.
// Assumes: one final beat per transaction, completions never exceed issues
// on a legal bus; the floor clamp only protects the monitor itself.
module lockrd_outstanding #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ar_hs,
    input  logic             r_done,
    output logic [CNT_W-1:0] pending,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             dec;

    // A completion only counts if something is in flight.
    assign dec = r_done && (cnt_q != '0);

    // Count after removing a completion that lands in this cycle.
    assign pending = dec ? cnt_q - 1'b1 : cnt_q;

    // Next count: saturating increment, guarded decrement, hold on both.
    always_comb begin
        cnt_d = cnt_q;
        if (ar_hs && !dec) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else if (!ar_hs && dec) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_hs && !r_done && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !r_done) |=> (cnt_q == CNT_MAX)); // R5
    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !ar_hs) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/lockrd_seq_fsm.sv
// Locked sequence tracker.
// Holds the sequence state and the attributes of the opening locked address,
// and raises one event bit per rule for the address presented in this cycle.
// Event bits are only meaningful when ar_hs is high.
// Assumes: pending and cnt_d come from the outstanding counter of the same cycle.
module lockrd_seq_fsm
    import lockrd_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int PAGE_W = 20,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_hs,
    input  logic              is_locked,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [PAGE_W-1:0] ar_page,
    input  logic [3:0]        ar_cache,
    input  logic [2:0]        ar_prot,
    input  logic [CNT_W-1:0]  pending,
    input  logic [CNT_W-1:0]  cnt_d,
    output mon_flags_t        ev,
    output seq_state_t        state_q
);
    seq_state_t        eff_state;
    seq_state_t        state_d;
    logic [ID_W-1:0]   id_q;
    logic [PAGE_W-1:0] page_q;
    logic [3:0]        cache_q;
    logic [2:0]        prot_q;
    logic [1:0]        nlock_q;
    logic              busy;
    logic              open_seq;

    assign busy = (pending != '0);

    // A closing phase whose reads have drained behaves as no sequence.
    assign eff_state = (state_q == ST_UNLOCKING && !busy) ? ST_IDLE : state_q;

    assign open_seq = ar_hs && is_locked && (eff_state == ST_IDLE);

    // Rule evaluation for the address presented this cycle.
    always_comb begin
        ev = '0;
        unique case (eff_state)
            ST_IDLE: begin
                ev.err_start = is_locked && busy;
            end
            ST_LOCKED: begin
                if (is_locked) begin
                    ev.err_id      = (ar_id != id_q);
                    ev.warn_region = (ar_page != page_q);
                    ev.warn_attr   = (ar_cache != cache_q) || (ar_prot != prot_q);
                    ev.warn_count  = (nlock_q >= 2'd2);
                end else begin
                    ev.err_last = busy;
                end
            end
            ST_UNLOCKING: begin
                ev.err_end = 1'b1;
            end
            default: ev = '0;
        endcase
    end

    // Next sequence state.
    always_comb begin
        state_d = eff_state;
        unique case (eff_state)
            ST_IDLE:      if (open_seq) state_d = ST_LOCKED;
            ST_LOCKED:    if (ar_hs && !is_locked) state_d = ST_UNLOCKING;
            ST_UNLOCKING: if (cnt_d == '0) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the opening address attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            page_q  <= '0;
            cache_q <= '0;
            prot_q  <= '0;
        end else if (open_seq) begin
            id_q    <= ar_id;
            page_q  <= ar_page;
            cache_q <= ar_cache;
            prot_q  <= ar_prot;
        end
    end

    // Count locked addresses in the sequence, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nlock_q <= '0;
        end else if (open_seq) begin
            nlock_q <= 2'd1;
        end else if (ar_hs && is_locked && eff_state == ST_LOCKED && nlock_q != 2'd3) begin
            nlock_q <= nlock_q + 2'd1;
        end
    end

    AST_LOCKED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOCKED && !(ar_hs && is_locked)) |=> (state_q != ST_LOCKED)); // R2
    AST_UNLOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNLOCKING && cnt_d == '0 && !(ar_hs && is_locked)) |=> (state_q == ST_IDLE)); // R5
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !ar_hs) |=> (state_q == ST_LOCKED)); // R4
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != 2'd3)); // R1

endmodule

// File: rtl/lockrd_flags.sv
// Sticky rule flags.
// Latches each event bit presented with an accepted address; bits clear only on reset.
module lockrd_flags
    import lockrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ar_hs,
    input  mon_flags_t ev,
    output mon_flags_t flags_q
);
    // Accumulate events on handshake cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (ar_hs) flags_q <= flags_q | ev;
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
    AST_FLAGS_NEED_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_hs |=> (flags_q == $past(flags_q))); // R9

endmodule

// File: rtl/lockrd_monitor.sv
// Locked read sequence monitor, top level.
// Observes read address and read data handshakes and reports violations of
// the locked read ordering rules as sticky error and warning bits.
// Assumes: ADDR_W > 12, reads complete with exactly one r_last beat each,
// reset is synchronous and active low.
module lockrd_monitor
    import lockrd_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [1:0]        ar_lock,
    input  logic [3:0]        ar_cache,
    input  logic [2:0]        ar_prot,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic              r_last,
    output logic              err_start,
    output logic              err_id,
    output logic              err_last,
    output logic              err_end,
    output logic              warn_count,
    output logic              warn_region,
    output logic              warn_attr
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    logic             ar_hs;
    logic             r_done;
    logic             is_locked;
    logic [CNT_W-1:0] pending;
    logic [CNT_W-1:0] cnt_d;
    mon_flags_t       ev;
    mon_flags_t       flags_q;
    seq_state_t       state_q;
    logic             unused_low_addr;

    assign ar_hs           = ar_valid && ar_ready;
    assign r_done          = r_valid && r_ready && r_last;
    assign is_locked       = (ar_lock == LOCK_LOCKED);
    assign unused_low_addr = ^ar_addr[PAGE_LSB-1:0];

    lockrd_outstanding #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ar_hs   (ar_hs),
        .r_done  (r_done),
        .pending (pending),
        .cnt_d   (cnt_d)
    );

    lockrd_seq_fsm #(.ID_W(ID_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ar_hs     (ar_hs),
        .is_locked (is_locked),
        .ar_id     (ar_id),
        .ar_page   (ar_addr[ADDR_W-1:PAGE_LSB]),
        .ar_cache  (ar_cache),
        .ar_prot   (ar_prot),
        .pending   (pending),
        .cnt_d     (cnt_d),
        .ev        (ev),
        .state_q   (state_q)
    );

    lockrd_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ar_hs   (ar_hs),
        .ev      (ev),
        .flags_q (flags_q)
    );

    assign err_start   = flags_q.err_start;
    assign err_id      = flags_q.err_id;
    assign err_last    = flags_q.err_last;
    assign err_end     = flags_q.err_end;
    assign warn_count  = flags_q.warn_count;
    assign warn_region = flags_q.warn_region;
    assign warn_attr   = flags_q.warn_attr;

    AST_START_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_hs && is_locked && state_q == ST_IDLE && pending != '0) |=> err_start); // R2
    AST_ID_MISMATCH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_hs && is_locked && state_q == ST_LOCKED && ev.err_id) |=> err_id); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0)); // R1

endmodule

// File: tb/lockrd_monitor_bench.sv
// Directed bench for the locked read sequence monitor.
module lockrd_monitor_bench;
    localparam int ID_W   = 4;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 6;
    localparam logic [1:0] LK = 2'b10;
    localparam logic [1:0] NL = 2'b00;
    localparam logic [6:0] F_START  = 7'b1000000;
    localparam logic [6:0] F_ID     = 7'b0100000;
    localparam logic [6:0] F_LAST   = 7'b0010000;
    localparam logic [6:0] F_END    = 7'b0001000;
    localparam logic [6:0] F_COUNT  = 7'b0000100;
    localparam logic [6:0] F_REGION = 7'b0000010;
    localparam logic [6:0] F_ATTR   = 7'b0000001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ar_valid = 1'b0;
    logic              ar_ready = 1'b0;
    logic [ID_W-1:0]   ar_id = '0;
    logic [ADDR_W-1:0] ar_addr = '0;
    logic [1:0]        ar_lock = '0;
    logic [3:0]        ar_cache = '0;
    logic [2:0]        ar_prot = '0;
    logic              r_valid = 1'b0;
    logic              r_ready = 1'b0;
    logic              r_last = 1'b0;
    logic              err_start, err_id, err_last, err_end;
    logic              warn_count, warn_region, warn_attr;
    logic [6:0]        flags;

    int n_checks = 0;
    int n_fail   = 0;

    assign flags = {err_start, err_id, err_last, err_end, warn_count, warn_region, warn_attr};

    always #5 clk = ~clk;

    lockrd_monitor #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_lockrd_monitor (
        .clk(clk), .rst_n(rst_n),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
        .ar_lock(ar_lock), .ar_cache(ar_cache), .ar_prot(ar_prot),
        .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
        .err_start(err_start), .err_id(err_id), .err_last(err_last), .err_end(err_end),
        .warn_count(warn_count), .warn_region(warn_region), .warn_attr(warn_attr)
    );

    task automatic check_flags(input logic [6:0] exp, input string req);
        n_checks++;
        if (flags !== exp) begin
            n_fail++;
            $display("FAIL %s: flags actual %b expected %b", req, flags, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle with an address presented; flags are read on return.
    task automatic ar_cycle(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                            input logic [1:0] lk, input logic [3:0] cache,
                            input logic [2:0] prot, input logic rdy, input logic with_r);
        ar_valid = 1'b1; ar_ready = rdy; ar_id = id; ar_addr = addr;
        ar_lock = lk; ar_cache = cache; ar_prot = prot;
        r_valid = with_r; r_ready = with_r; r_last = with_r;
        @(negedge clk);
        ar_valid = 1'b0; ar_ready = 1'b0; ar_lock = NL;
        r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0;
    endtask

    task automatic ar_go(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr, input logic [1:0] lk);
        ar_cycle(id, addr, lk, 4'b0011, 3'b000, 1'b1, 1'b0);
    endtask

    task automatic r_beat();
        r_valid = 1'b1; r_ready = 1'b1; r_last = 1'b1;
        @(negedge clk);
        r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0;
    endtask

    task automatic t_reset();
        ar_go(4'd1, 32'h0, NL);
        ar_go(4'd1, 32'h0, LK);
        do_reset();
        @(negedge clk);
        check_flags(7'b0, "R1 reset clears flags");
        ar_go(4'd1, 32'h1000, LK);
        check_flags(7'b0, "R1 count cleared by reset");
    endtask

    task automatic t_clean();
        do_reset();
        ar_go(4'd1, 32'h1000, LK); r_beat();
        ar_go(4'd1, 32'h1040, LK); r_beat();
        ar_go(4'd1, 32'h3000, NL); r_beat();
        @(negedge clk);
        ar_go(4'd2, 32'h5000, NL);
        check_flags(7'b0, "R3 R4 R5 legal sequence");
    endtask

    task automatic t_encoding();
        do_reset();
        ar_go(4'd1, 32'h0, NL);
        ar_go(4'd1, 32'h0, 2'b01);
        ar_go(4'd1, 32'h0, 2'b11);
        check_flags(7'b0, "R2 non-locked encodings open nothing");
    endtask

    task automatic t_start();
        do_reset();
        ar_go(4'd1, 32'h0, NL);
        ar_go(4'd1, 32'h1000, LK);
        check_flags(F_START, "R2 start with read outstanding");
    endtask

    task automatic t_start_same();
        do_reset();
        ar_go(4'd1, 32'h0, NL);
        ar_cycle(4'd1, 32'h1000, LK, 4'b0011, 3'b000, 1'b1, 1'b1);
        check_flags(7'b0, "R2 start with same-cycle completion");
        ar_cycle(4'd1, 32'h2000, NL, 4'b0011, 3'b000, 1'b1, 1'b1);
        check_flags(7'b0, "R4 close with same-cycle completion");
    endtask

    task automatic t_id();
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_go(4'd1, 32'h1010, LK);
        check_flags(7'b0, "R3 same ID accepted");
        ar_go(4'd2, 32'h1020, LK);
        check_flags(F_ID | F_COUNT, "R3 different ID");
    endtask

    task automatic t_last();
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_go(4'd1, 32'h2000, NL);
        check_flags(F_LAST, "R4 close before locked reads done");
    endtask

    task automatic t_end();
        do_reset();
        ar_go(4'd1, 32'h1000, LK); r_beat();
        ar_go(4'd1, 32'h2000, NL);
        ar_go(4'd3, 32'h3000, NL);
        check_flags(F_END, "R5 address before closing read done");
    endtask

    task automatic t_end_same();
        do_reset();
        ar_go(4'd1, 32'h1000, LK); r_beat();
        ar_go(4'd1, 32'h2000, NL);
        ar_cycle(4'd3, 32'h3000, NL, 4'b0011, 3'b000, 1'b1, 1'b1);
        check_flags(7'b0, "R5 address with same-cycle closing completion");
        r_beat();
        ar_go(4'd4, 32'h4000, LK);
        check_flags(7'b0, "R5 drained monitor opens new sequence");
    endtask

    task automatic t_count();
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_go(4'd1, 32'h1004, LK);
        check_flags(7'b0, "R6 two locked addresses");
        ar_go(4'd1, 32'h1008, LK);
        check_flags(F_COUNT, "R6 third locked address");
    endtask

    task automatic t_region();
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_go(4'd1, 32'h1ffc, LK);
        check_flags(7'b0, "R7 same page offset change");
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_go(4'd1, 32'h2000, LK);
        check_flags(F_REGION, "R7 page change");
    endtask

    task automatic t_attr();
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_cycle(4'd1, 32'h1010, LK, 4'b0011, 3'b001, 1'b1, 1'b0);
        check_flags(F_ATTR, "R8 prot change");
        do_reset();
        ar_go(4'd1, 32'h1000, LK);
        ar_cycle(4'd1, 32'h1010, LK, 4'b0010, 3'b000, 1'b1, 1'b0);
        check_flags(F_ATTR, "R8 cache change");
    endtask

    task automatic t_nohs();
        do_reset();
        ar_go(4'd1, 32'h0, NL);
        ar_cycle(4'd2, 32'h1000, LK, 4'b0011, 3'b000, 1'b0, 1'b0);
        check_flags(7'b0, "R9 unaccepted address ignored");
        ar_go(4'd1, 32'h1000, LK);
        r_beat(); r_beat();
        repeat (3) @(negedge clk);
        check_flags(F_START, "R9 flag sticky");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_clean();
        t_encoding();
        t_start();
        t_start_same();
        t_id();
        t_last();
        t_end();
        t_end_same();
        t_count();
        t_region();
        t_attr();
        t_nohs();
        finish_run();
    end
endmodule